// File: doc/BRIEF.md
# Coprocessor Cartridge Bus Arbiter

This block sits between a host CPU bus and a private ROM/SRAM bus. That private bus is shared with a coprocessor on the same cartridge. While the coprocessor does not hold the private bus, host reads of ROM and SRAM pass straight through, and so do host writes to SRAM.

The coprocessor asks for the bus in three ways: a code page fill, a DMA run, or a single access. Once it is granted, it owns the bus for the whole transfer. During that time the host is never made to wait. Its ROM and SRAM reads see zero, and its SRAM writes are discarded. A status byte tells software when the bus is taken.

A 32-byte vector register file stands in for the top of the ROM vector area while the coprocessor runs. The host can pause the coprocessor, either indefinitely or for a programmed number of cycles, and can resume it. Run/pause changes take effect only between host accesses.

A host access is one stretch of cycles with `hostCyc` high. The address may change within it, for example across the two bytes of a vector fetch. A cycle with `hostCyc` low is an access boundary.

Top module: `copbus_arbiter`

## Requirements
- R1: When `cpReq` is high, the coprocessor is running and the bus is free, `cpGrant` pulses at an access boundary and ownership starts on the next cycle. A fill (`cpKind`=0) gives 512 transfer cycles, a DMA (`cpKind`=1) gives `cpDmaLen` transfer cycles, and a single access (`cpKind`=2) gives one. `cpXfer` is high in each transfer cycle. Ownership ends one cycle after the last transfer.
- R2: A request raised while `hostCyc` is high is not granted until the first cycle with `hostCyc` low.
- R3: While the coprocessor owns the bus, host reads of ROM (0x8000–0xFFFF, outside the running vector window) and of SRAM return 0x00. Host writes do not reach `memWr`.
- R4: While the bus is free, host reads of ROM and SRAM (0x6000–0x6FFF) return `memRData` at the host address, and host SRAM writes drive `memWr`.
- R5: Host reads of addresses outside every decoded region return 0x00. With parameter `RAM_FITTED`=0, SRAM reads also return 0x00.
- R6: Reads of 0x7F53 return bit 7 = 1 while the coprocessor owns the bus and 0 otherwise. All other bits are 0.
- R7: Host writes to 0x7F60+i (i = 0..31) set vector byte i, which reads back at that address. While the coprocessor is running, a read of 0xFFE0+i returns vector byte i.
- R8: While the coprocessor is paused, reads of 0xFFE0–0xFFFF return ROM data.
- R9: Writing 0 to 0x7F55 pauses the coprocessor indefinitely, and no grant is given while it is paused. Writing a value with bit 0 set to 0x7F56 resumes it.
- R10: Writing L > 0 to 0x7F55 pauses the coprocessor and loads a countdown of L cycles. After the countdown ends, the coprocessor resumes at the next access boundary.
- R11: A pause or resume command takes effect only at an access boundary, so every byte within one host access sees the same run state.
- R12: Reads of 0x7F55 return the last value written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostCyc | input | 1 | Host access in progress |
| hostWr | input | 1 | Host access is a write |
| hostAddr | input | 16 | Host address |
| hostWData | input | 8 | Host write data |
| hostRData | output | 8 | Host read data (combinational) |
| cpReq | input | 1 | Coprocessor bus request, held until granted |
| cpKind | input | 2 | Request kind: 0 fill, 1 DMA, 2 single |
| cpDmaLen | input | CNT_W | DMA transfer count |
| cpAddr | input | 16 | Coprocessor memory address |
| cpWr | input | 1 | Coprocessor transfer is a write |
| cpWData | input | 8 | Coprocessor write data |
| cpGrant | output | 1 | Grant pulse |
| cpXfer | output | 1 | Transfer cycle |
| cpRData | output | 8 | Memory read data to the coprocessor |
| memAddr | output | 16 | Private bus address |
| memWr | output | 1 | Private bus write strobe |
| memWData | output | 8 | Private bus write data |
| memRData | input | 8 | Private bus read data |

## Verification
The hardest situation to reach from the ports is a pause command issued inside the same host access that then goes on to fetch vector bytes. The pause must not change the source of those bytes until the access ends. The stimulus holds `hostCyc` high across a write to the pause register followed by two vector reads, then reads the vector again after the boundary. It also raises a request in the middle of a multi-cycle host access, and keeps a request pending through an indefinite pause, to observe when the grant is delayed and when it is released.

// File: rtl/copbus_pkg.sv
package copbus_pkg;
  typedef enum logic [1:0] {
    REQ_FILL   = 2'd0,
    REQ_DMA    = 2'd1,
    REQ_SINGLE = 2'd2
  } reqKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic copOwn;
    logic copXfer;
    logic running;
  } ctlStrobe_t;

  localparam logic [15:0] ADDR_STATUS    = 16'h7F53;
  localparam logic [15:0] ADDR_PLEN      = 16'h7F55;
  localparam logic [15:0] ADDR_RESUME    = 16'h7F56;
  localparam logic [15:0] VEC_REG_BASE   = 16'h7F60;
  localparam logic [15:0] VEC_FETCH_BASE = 16'hFFE0;
endpackage

// File: rtl/copbus_ctrl.sv
module copbus_ctrl
  import copbus_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int FILL_BYTES = 512,
  parameter int PAUSE_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostCyc,
  input  logic               hostWr,
  input  logic [15:0]        hostAddr,
  input  logic [7:0]         hostWData,
  input  logic               cpReq,
  input  logic [1:0]         cpKind,
  input  logic [CNT_W-1:0]   cpDmaLen,
  output ctlStrobe_t         strobes,
  output logic               cpGrant,
  output logic [PAUSE_W-1:0] pauseLen
);
  localparam logic [CNT_W-1:0] FILL_LEN = CNT_W'(FILL_BYTES);

  logic               own;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   reqLen;
  logic               paused, timed, pendPause, pendResume;
  logic [PAUSE_W-1:0] pcnt;
  logic               boundary, wrPlen, wrResume, expired, grant, xfer;

  always_comb begin
    case (reqKind_e'(cpKind))
      REQ_FILL: reqLen = FILL_LEN;
      REQ_DMA:  reqLen = cpDmaLen;
      default:  reqLen = CNT_W'(1);
    endcase
  end

  assign boundary = !hostCyc;
  assign wrPlen   = hostCyc && hostWr && (hostAddr == ADDR_PLEN);
  assign wrResume = hostCyc && hostWr && (hostAddr == ADDR_RESUME) && hostWData[0];
  assign expired  = paused && timed && (pcnt == '0);
  assign grant    = !own && cpReq && !paused && boundary;
  assign xfer     = own && (cnt != '0);

  // Bus ownership: N transfer cycles, then one tail cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      own <= 1'b0;
      cnt <= '0;
    end else if (own) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      else           own <= 1'b0;
    end else if (grant) begin
      own <= 1'b1;
      cnt <= reqLen;
    end
  end

  // Run/pause state, committed only at access boundaries
  always_ff @(posedge clk) begin
    if (!rstN) begin
      paused     <= 1'b0;
      timed      <= 1'b0;
      pcnt       <= '0;
      pendPause  <= 1'b0;
      pendResume <= 1'b0;
      pauseLen   <= '0;
    end else begin
      if (wrPlen) pauseLen <= hostWData[PAUSE_W-1:0];
      if (boundary) begin
        pendPause  <= 1'b0;
        pendResume <= 1'b0;
      end else if (wrPlen) begin
        pendPause  <= 1'b1;
        pendResume <= 1'b0;
      end else if (wrResume) begin
        pendResume <= 1'b1;
        pendPause  <= 1'b0;
      end
      if (boundary && pendPause) begin
        paused <= 1'b1;
        timed  <= (pauseLen != '0);
        pcnt   <= pauseLen;
      end else begin
        if (boundary && (pendResume || expired)) paused <= 1'b0;
        if (paused && timed && (pcnt != '0)) pcnt <= pcnt - 1'b1;
      end
    end
  end

  assign strobes.copOwn  = own;
  assign strobes.copXfer = xfer;
  assign strobes.running = !paused;
  assign cpGrant         = grant;

  // R1
  tail_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    own && !xfer |=> !own);
  // R2
  grant_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(own) |-> $past(!hostCyc && !paused));
  // R11
  switch_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(paused) |-> $past(!hostCyc));
  // R10
  early_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    paused && timed && (pcnt != '0) |=> paused);
endmodule

// File: rtl/copbus_datapath.sv
module copbus_datapath
  import copbus_pkg::*;
#(
  parameter int          PAUSE_W    = 8,
  parameter int          VEC_BYTES  = 32,
  parameter int          SRAM_AW    = 12,
  parameter logic [15:0] SRAM_BASE  = 16'h6000,
  parameter bit          RAM_FITTED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobes,
  input  logic [PAUSE_W-1:0] pauseLen,
  input  logic               hostCyc,
  input  logic               hostWr,
  input  logic [15:0]        hostAddr,
  input  logic [7:0]         hostWData,
  output logic [7:0]         hostRData,
  input  logic [15:0]        cpAddr,
  input  logic               cpWr,
  input  logic [7:0]         cpWData,
  output logic [7:0]         cpRData,
  output logic [15:0]        memAddr,
  output logic               memWr,
  output logic [7:0]         memWData,
  input  logic [7:0]         memRData
);
  localparam int IDX_W = $clog2(VEC_BYTES);

  logic [7:0]       vecReg [VEC_BYTES];
  logic [IDX_W-1:0] idx;
  logic             vecRegHit, fetchHit, sramHit, sramWrOk;
  logic [7:0]       sramRd;

  assign idx       = hostAddr[IDX_W-1:0];
  assign vecRegHit = hostAddr[15:IDX_W] == VEC_REG_BASE[15:IDX_W];
  assign fetchHit  = hostAddr[15:IDX_W] == VEC_FETCH_BASE[15:IDX_W];
  assign sramHit   = hostAddr[15:SRAM_AW] == SRAM_BASE[15:SRAM_AW];

  for (genvar i = 0; i < VEC_BYTES; i++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN) vecReg[i] <= '0;
      else if (hostCyc && hostWr && vecRegHit && (idx == IDX_W'(i)))
        vecReg[i] <= hostWData;
    end
  end

  if (RAM_FITTED) begin : g_ram
    assign sramRd   = strobes.copOwn ? 8'h00 : memRData;
    assign sramWrOk = 1'b1;
  end else begin : g_noram
    assign sramRd   = 8'h00;
    assign sramWrOk = 1'b0;
  end

  always_comb begin
    hostRData = 8'h00;
    if (hostAddr == ADDR_STATUS)               hostRData = {strobes.copOwn, 7'b0};
    else if (hostAddr == ADDR_PLEN)            hostRData = 8'(pauseLen);
    else if (vecRegHit)                        hostRData = vecReg[idx];
    else if (fetchHit && strobes.running)      hostRData = vecReg[idx];
    else if (hostAddr[15])                     hostRData = strobes.copOwn ? 8'h00 : memRData;
    else if (sramHit)                          hostRData = sramRd;
  end

  assign memAddr  = strobes.copOwn ? cpAddr : hostAddr;
  assign memWData = strobes.copOwn ? cpWData : hostWData;
  assign memWr    = strobes.copOwn ? (strobes.copXfer && cpWr)
                                   : (hostCyc && hostWr && sramHit && sramWrOk);
  assign cpRData  = memRData;

  // R3
  rom_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.copOwn && hostCyc && hostAddr[15] && !fetchHit |-> hostRData == 8'h00);
  // R3
  host_write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.copOwn && hostCyc && hostWr && !strobes.copXfer |-> !memWr);
endmodule

// File: rtl/copbus_arbiter.sv
module copbus_arbiter
  import copbus_pkg::*;
#(
  parameter int          CNT_W      = 10,
  parameter int          FILL_BYTES = 512,
  parameter int          PAUSE_W    = 8,
  parameter int          VEC_BYTES  = 32,
  parameter int          SRAM_AW    = 12,
  parameter logic [15:0] SRAM_BASE  = 16'h6000,
  parameter bit          RAM_FITTED = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostCyc,
  input  logic             hostWr,
  input  logic [15:0]      hostAddr,
  input  logic [7:0]       hostWData,
  output logic [7:0]       hostRData,
  input  logic             cpReq,
  input  logic [1:0]       cpKind,
  input  logic [CNT_W-1:0] cpDmaLen,
  input  logic [15:0]      cpAddr,
  input  logic             cpWr,
  input  logic [7:0]       cpWData,
  output logic             cpGrant,
  output logic             cpXfer,
  output logic [7:0]       cpRData,
  output logic [15:0]      memAddr,
  output logic             memWr,
  output logic [7:0]       memWData,
  input  logic [7:0]       memRData
);
  ctlStrobe_t         strobes;
  logic [PAUSE_W-1:0] pauseLen;

  copbus_ctrl #(.CNT_W(CNT_W), .FILL_BYTES(FILL_BYTES), .PAUSE_W(PAUSE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostCyc(hostCyc), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWData(hostWData), .cpReq(cpReq),
    .cpKind(cpKind), .cpDmaLen(cpDmaLen), .strobes(strobes),
    .cpGrant(cpGrant), .pauseLen(pauseLen)
  );

  copbus_datapath #(.PAUSE_W(PAUSE_W), .VEC_BYTES(VEC_BYTES), .SRAM_AW(SRAM_AW),
                    .SRAM_BASE(SRAM_BASE), .RAM_FITTED(RAM_FITTED)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pauseLen(pauseLen),
    .hostCyc(hostCyc), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWData(hostWData), .hostRData(hostRData), .cpAddr(cpAddr),
    .cpWr(cpWr), .cpWData(cpWData), .cpRData(cpRData), .memAddr(memAddr),
    .memWr(memWr), .memWData(memWData), .memRData(memRData)
  );

  assign cpXfer = strobes.copXfer;
endmodule

// File: tb/copbus_arbiter_tb.sv
module copbus_arbiter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCyc = 0, hostWr = 0;
  logic [15:0] hostAddr = '0;
  logic [7:0] hostWData = '0;
  logic [7:0] hostRData;
  logic cpReq = 0;
  logic [1:0] cpKind = 2'd2;
  logic [9:0] cpDmaLen = '0;
  logic [15:0] cpAddr = '0;
  logic cpWr = 0;
  logic [7:0] cpWData = '0;
  logic cpGrant, cpXfer;
  logic [7:0] cpRData;
  logic [15:0] memAddr;
  logic memWr;
  logic [7:0] memWData, memRData;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  copbus_arbiter u_dut (
    .clk(clk), .rstN(rstN), .hostCyc(hostCyc), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWData(hostWData), .hostRData(hostRData),
    .cpReq(cpReq), .cpKind(cpKind), .cpDmaLen(cpDmaLen), .cpAddr(cpAddr),
    .cpWr(cpWr), .cpWData(cpWData), .cpGrant(cpGrant), .cpXfer(cpXfer),
    .cpRData(cpRData), .memAddr(memAddr), .memWr(memWr),
    .memWData(memWData), .memRData(memRData)
  );

  // External memory model
  logic [7:0] sram [4096];
  function automatic logic [7:0] romByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic bit inSram(input logic [15:0] a);
    return a[15:12] == 4'h6;
  endfunction
  assign memRData = memAddr[15] ? romByte(memAddr)
                  : (inSram(memAddr) ? sram[memAddr[11:0]] : 8'h00);
  always @(posedge clk) if (memWr && inSram(memAddr)) sram[memAddr[11:0]] <= memWData;

  // Behavioural reference model
  bit mOwn, mPaused, mTimed, mPendP, mPendR;
  int mCnt, mPCnt;
  logic [7:0] mLen;
  logic [7:0] mVec [32];

  function automatic logic [7:0] expRead(input logic [15:0] a);
    if (a == 16'h7F53) return {mOwn, 7'b0};
    if (a == 16'h7F55) return mLen;
    if (a >= 16'h7F60 && a <= 16'h7F7F) return mVec[a[4:0]];
    if (a >= 16'hFFE0 && !mPaused) return mVec[a[4:0]];
    if (a[15]) return mOwn ? 8'h00 : romByte(a);
    if (inSram(a)) return mOwn ? 8'h00 : sram[a[11:0]];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOwn = 0; mPaused = 0; mTimed = 0; mPendP = 0; mPendR = 0;
      mCnt = 0; mPCnt = 0; mLen = 0;
      foreach (mVec[i]) mVec[i] = 8'h00;
    end else begin
      bit bnd, gnt, expd, oldPaused, oldTimed, oldPendP, oldPendR;
      int oldPCnt, lenReq;
      logic [7:0] oldLen;
      bnd = !hostCyc;
      gnt = !mOwn && cpReq && !mPaused && bnd;
      expd = mPaused && mTimed && mPCnt == 0;
      oldPaused = mPaused; oldTimed = mTimed; oldPCnt = mPCnt;
      oldPendP = mPendP; oldPendR = mPendR; oldLen = mLen;
      lenReq = (cpKind == 2'd0) ? 512 : (cpKind == 2'd1) ? int'(cpDmaLen) : 1;
      if (mOwn) begin
        if (mCnt != 0) mCnt--; else mOwn = 0;
      end else if (gnt) begin
        mOwn = 1; mCnt = lenReq;
      end
      if (hostCyc && hostWr && hostAddr >= 16'h7F60 && hostAddr <= 16'h7F7F)
        mVec[hostAddr[4:0]] = hostWData;
      if (hostCyc && hostWr && hostAddr == 16'h7F55) begin
        mLen = hostWData; mPendP = 1; mPendR = 0;
      end else if (hostCyc && hostWr && hostAddr == 16'h7F56 && hostWData[0]) begin
        mPendR = 1; mPendP = 0;
      end
      if (bnd) begin mPendP = 0; mPendR = 0; end
      if (bnd && oldPendP) begin
        mPaused = 1; mTimed = (oldLen != 0); mPCnt = oldLen;
      end else begin
        if (bnd && (oldPendR || expd)) mPaused = 0;
        if (oldPaused && oldTimed && oldPCnt != 0) mPCnt = oldPCnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string readTag(input logic [15:0] a);
    if (a == 16'h7F53) return "R6 status read";
    if (a == 16'h7F55) return "R12 length readback";
    if (a >= 16'hFFE0) return "R7/R8 vector read";
    if (a >= 16'h7F60 && a <= 16'h7F7F) return "R7 vector register read";
    if (a[15] || inSram(a)) return "R3/R4 memory read";
    return "R5 unmapped read";
  endfunction

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit eGrant, eXfer, eWr;
      eGrant = !mOwn && cpReq && !mPaused && !hostCyc;
      eXfer  = mOwn && mCnt != 0;
      eWr    = mOwn ? (eXfer && cpWr) : (hostCyc && hostWr && inSram(hostAddr));
      check(cpGrant == eGrant, "R1/R2/R9 grant", cpGrant, eGrant);
      check(cpXfer == eXfer, "R1 transfer", cpXfer, eXfer);
      check(memWr == eWr, "R3/R4 memWr", memWr, eWr);
      if (hostCyc) check(hostRData == expRead(hostAddr), readTag(hostAddr),
                         hostRData, expRead(hostAddr));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      check(0, "watchdog expired", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hostWrite(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1 hostCyc = 1; hostWr = 1; hostAddr = a; hostWData = d;
    @(posedge clk); #1 hostCyc = 0; hostWr = 0;
  endtask

  task automatic hostRead(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1 hostCyc = 1; hostWr = 0; hostAddr = a;
    @(negedge clk) check(hostRData == exp, tag, hostRData, exp);
    @(posedge clk); #1 hostCyc = 0;
  endtask

  task automatic copRequest(input logic [1:0] k, input int n, input logic [15:0] a,
                            input logic w, input logic [7:0] d);
    @(posedge clk); #1 cpReq = 1; cpKind = k; cpDmaLen = 10'(n);
    cpAddr = a; cpWr = w; cpWData = d;
    forever begin
      @(negedge clk);
      if (cpGrant) break;
    end
    @(posedge clk); #1 cpReq = 0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) sram[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk) check(cpXfer == 0 && cpGrant == 0, "reset idle outputs", cpXfer, 0);
    hostRead(16'h7F53, 8'h00, "R6 reset status");
    hostRead(16'hFFE0, 8'h00, "R7 reset vector");

    for (int i = 0; i < 32; i++) hostWrite(16'h7F60 + 16'(i), 8'hA0 + 8'(i));
    hostRead(16'h7F7F, 8'hBF, "R7 vector register readback");
    // two-byte vector fetch in one access
    @(posedge clk); #1 hostCyc = 1; hostAddr = 16'hFFEA;
    @(negedge clk) check(hostRData == 8'hAA, "R7 vector low byte", hostRData, 8'hAA);
    @(posedge clk); #1 hostAddr = 16'hFFEB;
    @(negedge clk) check(hostRData == 8'hAB, "R7 vector high byte", hostRData, 8'hAB);
    @(posedge clk); #1 hostCyc = 0;

    hostWrite(16'h6010, 8'h3C);
    hostRead(16'h6010, 8'h3C, "R4 SRAM write then read");
    hostRead(16'h8123, romByte(16'h8123), "R4 ROM read");
    hostRead(16'h4000, 8'h00, "R5 unmapped read");
    hostRead(16'h7000, 8'h00, "R5 gap read");

    // single access: one transfer, then one tail cycle
    copRequest(2'd2, 0, 16'h8004, 1'b0, 8'h00);
    hostRead(16'h7F53, 8'h80, "R1 tail cycle still owned");
    hostRead(16'h7F53, 8'h00, "R1 released after tail");

    // cache fill with host traffic during it
    copRequest(2'd0, 0, 16'h8200, 1'b0, 8'h00);
    hostRead(16'h8123, 8'h00, "R3 ROM blocked");
    hostRead(16'h7F53, 8'h80, "R6 busy bit");
    hostWrite(16'h6020, 8'h77);
    hostRead(16'h6010, 8'h00, "R3 SRAM blocked");
    repeat (520) @(posedge clk);
    hostRead(16'h6020, 8'h00, "R3 write dropped");
    hostRead(16'h7F53, 8'h00, "R1 fill released");

    // DMA writes to SRAM
    copRequest(2'd1, 5, 16'h6030, 1'b1, 8'h99);
    repeat (8) @(posedge clk);
    hostRead(16'h6030, 8'h99, "R1 DMA reached SRAM");

    // request raised inside a three-cycle host access
    @(posedge clk); #1 hostCyc = 1; hostAddr = 16'h8001; cpReq = 1; cpKind = 2'd2;
    cpWr = 0; cpAddr = 16'h8002;
    @(negedge clk) check(cpGrant == 0, "R2 no grant mid access", cpGrant, 0);
    @(posedge clk); #1;
    @(negedge clk) check(cpGrant == 0, "R2 no grant mid access", cpGrant, 0);
    @(posedge clk); #1;
    @(negedge clk) check(cpGrant == 0, "R2 no grant mid access", cpGrant, 0);
    @(posedge clk); #1 hostCyc = 0;
    @(negedge clk) check(cpGrant == 1, "R2 grant at boundary", cpGrant, 1);
    @(posedge clk); #1 cpReq = 0;
    repeat (4) @(posedge clk);

    // indefinite pause
    hostWrite(16'h7F55, 8'h00);
    hostRead(16'hFFE0, romByte(16'hFFE0), "R8 paused vector from ROM");
    @(posedge clk); #1 cpReq = 1; cpKind = 2'd2;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) check(cpGrant == 0, "R9 no grant while paused", cpGrant, 0);
    end
    hostWrite(16'h7F56, 8'h01);
    begin
      bit got;
      got = 0;
      for (int i = 0; i < 6 && !got; i++) begin
        @(negedge clk);
        if (cpGrant) got = 1;
      end
      check(got, "R9 grant after resume", got, 1);
    end
    @(posedge clk); #1 cpReq = 0;
    repeat (4) @(posedge clk);

    // timed pause of 6 cycles
    hostWrite(16'h7F55, 8'h06);
    hostRead(16'hFFE1, romByte(16'hFFE1), "R10 still paused");
    repeat (12) @(posedge clk);
    hostRead(16'hFFE1, 8'hA1, "R10 resumed on its own");
    hostRead(16'h7F55, 8'h06, "R12 length readback");

    // pause command inside a vector fetch access
    @(posedge clk); #1 hostCyc = 1; hostWr = 1; hostAddr = 16'h7F55; hostWData = 8'h00;
    @(posedge clk); #1 hostWr = 0; hostAddr = 16'hFFE2;
    @(negedge clk) check(hostRData == 8'hA2, "R11 same run state low", hostRData, 8'hA2);
    @(posedge clk); #1 hostAddr = 16'hFFE3;
    @(negedge clk) check(hostRData == 8'hA3, "R11 same run state high", hostRData, 8'hA3);
    @(posedge clk); #1 hostCyc = 0;
    hostRead(16'hFFE2, romByte(16'hFFE2), "R11 pause after boundary");
    hostWrite(16'h7F56, 8'h01);
    hostRead(16'hFFE2, 8'hA2, "R9 resumed vector");

    repeat (3) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule